// File: doc/BRIEF.md
# Sub-Clock Interval Timer with Period Taps

This block is a free-running 15-bit up-counter timed by a low-speed sub-clock. The sub-clock is not a separate clock net. A divide-by-four prescaler runs on the oscillator clock and issues a one-cycle advance strobe every fourth oscillator cycle, so everything lives in one clock domain. Each time the counter advances it runs whatever the system clock selection is, because that selection is not an input of the block.

One counter serves three consumers:
- A sticky interval flag. Its period is chosen from seven power-of-two values, and the flag is gated by an enable to form the interrupt request.
- A fixed pulse for the oscillator-stabilization wait.
- A pulse for a watchdog, with a period chosen from four values.

Each event fires when the advance makes counter bit (n-1) fall, where n is the chosen period exponent. An event therefore occurs once every 2^n sub-clock periods, counted from a counter clear.

Top module: `subclk_interval_timer`

## Requirements
- R1: While reset is held, and in the cycle after its release, `irq`, `stab_pulse` and `wdog_tick` are all 0.
- R2: The counter advances exactly once every four `clk` cycles. The first advance after a counter clear comes on the fourth rising edge after the edge that sampled the clear.
- R3: `ival_sel` code k in 0..6 selects a period of 2^(9+k) sub-clock periods. After a counter clear, the flag is first seen set 4*2^(9+k) clock edges after the clearing edge: 2048 for code 0 and 4096 for code 1.
- R4: `ival_sel` code 7 behaves exactly like code 6, with a period of 2^15 sub-clock periods, or 131072 clock edges.
- R5: Once set, the flag stays set until `flag_clr` is sampled high. A `flag_clr` sampled with no event in the same cycle clears it.
- R6: When an interval event and `flag_clr` occur in the same cycle, the flag ends up set.
- R7: `irq` equals the flag ANDed with `irq_en`. Changing `irq_en` never alters the flag.
- R8: `cnt_clr` returns the counter and the prescaler to zero and leaves the flag unchanged. A clear never produces an event.
- R9: `stab_pulse` is a one-cycle pulse every 2^14 sub-clock periods. After a counter clear, the first pulse is seen 65536 clock edges after the clearing edge.
- R10: `wdog_tick` is a one-cycle pulse whose period is selected by `wdog_sel`: 0 selects 2^10, 1 selects 2^13, 2 selects 2^14 and 3 selects 2^15 sub-clock periods.
- R11: The counter wraps from its maximum value to 0. That wrap is the event for every period whose exponent is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also times the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| ival_sel | input | 3 | Interval period code (0..6 give 2^9..2^15; 7 acts as 6) |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Clears the interval flag (an event in the same cycle takes priority) |
| cnt_clr | input | 1 | Zeroes the counter and the prescaler |
| wdog_sel | input | 2 | Watchdog period code |
| irq | output | 1 | Interval interrupt request |
| stab_pulse | output | 1 | Stabilization-wait period pulse |
| wdog_tick | output | 1 | Watchdog period pulse |

## Verification
The hardest condition to reach is the longest period. Code 7, watchdog code 3 and the counter's own wrap each need 131072 oscillator cycles from a clear, and no port can preload the counter. The stimulus therefore clears the counter once and runs a single undisturbed pass through the whole range. During that pass it timestamps the first stabilization pulse and the wrap event.

The set-versus-clear collision is the other hard case. It needs `flag_clr` to arrive in exactly the cycle of an event. The bench predicts that cycle from its own tick model and places the clear there. Shorter periods are covered by seeded random changes of the selects, clears and enable, which are checked against that model every cycle.

// File: rtl/subclk_tmr_pkg.sv
package subclk_tmr_pkg;

    // registered event outputs of the timer
    typedef struct packed {
        logic flag;
        logic stab;
        logic wdog;
    } evt_regs_t;

    // interval code to period exponent; codes past the counter width saturate
    function automatic int code_to_exp(input int code, input int min_exp, input int max_exp);
        int e;
        e = min_exp + code;
        if (e > max_exp) e = max_exp;
        return e;
    endfunction

endpackage

// File: rtl/subclk_counter.sv
module subclk_counter #(
    parameter int DIV_W = 2,
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] fall
);
    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t             st_d, st_q;
    logic             step;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        step    = (&st_q.pre) && !clr;
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        fall    = '0;
        if (clr) begin
            st_d.pre = '0;
            st_d.cnt = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
            if (step) begin
                st_d.cnt = cnt_inc;
                fall     = st_q.cnt & ~cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R8: a clear returns counter and prescaler to zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0 && st_q.pre == '0));

    // R2: between prescaler strobes the count holds
    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(&st_q.pre)) |=> $stable(st_q.cnt));

endmodule

// File: rtl/subclk_event_regs.sv
module subclk_event_regs
    import subclk_tmr_pkg::*;
#(
    parameter int CNT_W    = 15,
    parameter int SEL_W    = 3,
    parameter int MIN_EXP  = 9,
    parameter int STAB_EXP = 14,
    parameter int WD_SEL_W = 2,
    parameter int WD_EXP [2**WD_SEL_W] = '{10, 13, 14, 15}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    fall,
    input  logic [SEL_W-1:0]    ival_sel,
    input  logic [WD_SEL_W-1:0] wdog_sel,
    input  logic                flag_clr,
    output logic                flag,
    output logic                stab,
    output logic                wdog
);
    localparam int IDX_W = $clog2(CNT_W);

    evt_regs_t        st_d, st_q;
    logic [IDX_W-1:0] ival_idx;
    logic [IDX_W-1:0] wd_idx;
    logic             ival_evt;

    always_comb begin
        ival_idx = IDX_W'(code_to_exp(int'(ival_sel), MIN_EXP, CNT_W) - 1);
        wd_idx   = IDX_W'(WD_EXP[wdog_sel] - 1);
        ival_evt = fall[ival_idx];
        st_d.stab = fall[STAB_EXP-1];
        st_d.wdog = fall[wd_idx];
        if (ival_evt)      st_d.flag = 1'b1;
        else if (flag_clr) st_d.flag = 1'b0;
        else               st_d.flag = st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign stab = st_q.stab;
    assign wdog = st_q.wdog;

    // R5: flag sticks until cleared
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !flag_clr) |=> st_q.flag);

    // R6: event beats a simultaneous clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ival_evt && flag_clr) |=> st_q.flag);

    // R9: stabilization pulse lasts a single cycle
    p_stab_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stab |=> !st_q.stab);

    // R10: watchdog pulse lasts a single cycle
    p_wdog_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wdog |=> !st_q.wdog);

endmodule

// File: rtl/subclk_interval_timer.sv
module subclk_interval_timer #(
    parameter int DIV_W    = 2,
    parameter int CNT_W    = 15,
    parameter int SEL_W    = 3,
    parameter int MIN_EXP  = 9,
    parameter int STAB_EXP = 14,
    parameter int WD_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    ival_sel,
    input  logic                irq_en,
    input  logic                flag_clr,
    input  logic                cnt_clr,
    input  logic [WD_SEL_W-1:0] wdog_sel,
    output logic                irq,
    output logic                stab_pulse,
    output logic                wdog_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] fall;
    logic             flag;

    subclk_counter #(
        .DIV_W (DIV_W),
        .CNT_W (CNT_W)
    ) u_counter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .cnt  (cnt),
        .fall (fall)
    );

    subclk_event_regs #(
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .MIN_EXP (MIN_EXP),
        .STAB_EXP(STAB_EXP),
        .WD_SEL_W(WD_SEL_W)
    ) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (fall),
        .ival_sel(ival_sel),
        .wdog_sel(wdog_sel),
        .flag_clr(flag_clr),
        .flag    (flag),
        .stab    (stab_pulse),
        .wdog    (wdog_tick)
    );

    assign irq = flag & irq_en;

    // R8: a counter clear leaves a set flag alone
    p_flag_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && flag && !flag_clr) |=> flag);

    // R11: the stabilization pulse only follows a count landing on a 2^14 boundary
    p_stab_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stab_pulse |-> (cnt[STAB_EXP-1:0] == '0));

endmodule

// File: tb/test_subclk_interval_timer.sv
module test_subclk_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ival_sel = '0;
    logic       irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cnt_clr = 1'b0;
    logic [1:0] wdog_sel = '0;
    logic       irq, stab_pulse, wdog_tick;

    int  n_chk = 0;
    int  n_err = 0;
    bit  chk_on = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    subclk_interval_timer i_subclk_interval_timer (
        .clk(clk), .rst_n(rst_n), .ival_sel(ival_sel), .irq_en(irq_en),
        .flag_clr(flag_clr), .cnt_clr(cnt_clr), .wdog_sel(wdog_sel),
        .irq(irq), .stab_pulse(stab_pulse), .wdog_tick(wdog_tick)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // period exponents from the requirements (R3, R4, R10)
    function automatic int ival_exp(input logic [2:0] code);
        return (code >= 3'd6) ? 15 : 9 + int'(code);
    endfunction

    function automatic int wd_exp(input logic [1:0] code);
        case (code)
            2'd0:    return 10;
            2'd1:    return 13;
            2'd2:    return 14;
            default: return 15;
        endcase
    endfunction

    // reference model: prescale phase and sub-clock ticks since clear
    int unsigned m_pre, m_t;
    bit m_flag, m_stab, m_wd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_t = 0; m_flag = 0; m_stab = 0; m_wd = 0;
        end else begin
            bit set;
            set = 0; m_stab = 0; m_wd = 0;
            if (cnt_clr) begin
                m_pre = 0; m_t = 0;
            end else if (m_pre == 3) begin
                m_pre = 0;
                m_t = (m_t + 1) % 32768;
                if (m_t % (32'd1 << ival_exp(ival_sel)) == 0) set = 1;
                if (m_t % 16384 == 0) m_stab = 1;
                if (m_t % (32'd1 << wd_exp(wdog_sel)) == 0) m_wd = 1;
            end else begin
                m_pre = m_pre + 1;
            end
            if (set) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    function automatic bit event_next();
        return !cnt_clr && m_pre == 3 &&
               ((m_t + 1) % (32'd1 << ival_exp(ival_sel)) == 0);
    endfunction

    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            #0.5;
            check("R3 irq vs model", irq, m_flag & irq_en);
            check("R9 stab_pulse vs model", stab_pulse, m_stab);
            check("R10 wdog_tick vs model", wdog_tick, m_wd);
        end
    end

    // clear counter and flag, then count edges until irq appears
    task automatic measure(input logic [2:0] code, input int exp_n, input string tag,
                           output int stab_at, output bit wd_at_irq);
        int n;
        @(negedge clk);
        ival_sel = code; irq_en = 1; cnt_clr = 1; flag_clr = 1;
        @(negedge clk);
        cnt_clr = 0; flag_clr = 0;
        n = 0; stab_at = -1;
        while (!irq && n < 140000) begin
            @(negedge clk); #1;
            n++;
            if (stab_pulse && stab_at < 0) stab_at = n;
        end
        wd_at_irq = wdog_tick;
        check_int(tag, n, exp_n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int  st;
        bit  wdt;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 irq in reset", irq, 1'b0);
        check("R1 stab in reset", stab_pulse, 1'b0);
        check("R1 wdog in reset", wdog_tick, 1'b0);
        rst_n = 1;
        @(negedge clk); #1;
        check("R1 irq after release", irq, 1'b0);
        check("R1 wdog after release", wdog_tick, 1'b0);
        chk_on = 1;

        // R2, R3, R8: exact periods from a clear
        measure(3'd0, 2048, "R3 code0 period (R2 R8)", st, wdt);
        measure(3'd1, 4096, "R3 code1 period", st, wdt);

        // R5: flag is sticky
        repeat (100) @(negedge clk);
        #1; check("R5 flag sticky", irq, 1'b1);

        // R7: enable gates the request, flag untouched
        @(negedge clk); irq_en = 0; #1;
        check("R7 irq masked", irq, 1'b0);
        @(negedge clk); irq_en = 1; #1;
        check("R7 flag kept under mask", irq, 1'b1);

        // R8: counter clear keeps the flag
        @(negedge clk); cnt_clr = 1;
        @(negedge clk); cnt_clr = 0; #1;
        check("R8 flag kept over cnt_clr", irq, 1'b1);

        // R5: plain clear
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0; #1;
        check("R5 flag cleared", irq, 1'b0);

        // R6: clear in the exact event cycle
        ival_sel = 3'd0;
        while (!event_next()) @(negedge clk);
        flag_clr = 1;
        @(negedge clk); flag_clr = 0; #1;
        check("R6 set wins over clear", irq, 1'b1);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;

        // random phase on the short periods
        for (int i = 0; i < 15000; i++) begin
            @(negedge clk);
            if (($urandom % 2000) == 0) ival_sel = 3'($urandom % 3);
            if (($urandom % 3000) == 0) wdog_sel = 2'($urandom % 2);
            if (($urandom % 256) == 0) irq_en = 1'($urandom);
            flag_clr = (($urandom % 64) == 0);
            cnt_clr  = (($urandom % 4096) == 0);
        end
        @(negedge clk); flag_clr = 0; cnt_clr = 0;

        // R4, R9, R10, R11: one full pass of the counter
        wdog_sel = 2'd3;
        measure(3'd7, 131072, "R4 code7 equals 2^15 period", st, wdt);
        check_int("R9 first stab pulse", st, 65536);
        check("R10 R11 wdog at wrap", wdt, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule